// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel up and down in fixed, timed steps when software flips a single target-on control bit. It drives three enables: panel supply, panel signals and backlight. Every sub-step waits for its own programmed delay, counted in prescaled ticks. On the way up the supply comes on first, then the signals, then the backlight is permitted. The way down runs in the reverse order.

After the supply drops, the block enforces a mandatory off-time, the power-cycle delay, before it will accept another power-up. A power-up request that arrives during that window is held until the window ends. The block also leaves its halted state through the same off-time.

A 32-bit status word shows the following: whether the panel is live, whether the sequencer is running, which way a sequence is moving, whether the off-time is still counting, and the exact sub-step code. Software polls this word for a completion signature and does not time the steps itself. A separate force-supply bit can hold the supply on outside any sequence.

Top module: `pnl_pwr_seq`

## Requirements
- R1: While `ctl_seq_run` is low, all three enables are low at once, the state code reads 0xF one clock later, the ready bit is clear and target-on requests have no effect.
- R2: Status layout: bit 31 panel-live, bit 30 ready, bits 29:28 direction (0 none, 1 up, 2 down), bit 27 off-time active, bits 3:0 state code; every other bit reads zero.
- R3: Power-up runs through codes 0x9, 0xA, 0xB, 0x8. Supply is on from 0x9, signals from 0xA, and the backlight is permitted from 0xB. A power-up starts only from code 0x0.
- R4: Clearing target-on at code 0x8 runs codes 0x1, 0x2, 0x3, 0x0. The backlight is off from 0x1, signals off from 0x2 and supply off from 0x3. A power-down starts only from code 0x8.
- R5: Each up sub-step lasts `dly_on`*TICK_DIV+1 clocks and each down sub-step lasts `dly_off`*TICK_DIV+1 clocks.
- R6: Power-up complete reads panel-live 1, direction 0, code 0x8. Power-down complete reads panel-live 0, direction 0, code 0x0, and off-time clear.
- R7: Code 0x0 entered from 0x3, or from the halted state, sets the off-time flag for `dly_cycle`*TICK_DIV+1 clocks. A pending power-up then moves to 0x9 exactly one clock after the flag clears, so code 0x0 lasts `dly_cycle`*TICK_DIV+2 clocks.
- R8: With the sequencer running, `ctl_force_supply` raises the supply enable without changing the state code or the signal enable. Clearing all four control bits together drops every enable immediately and the code reads 0xF.
- R9: The backlight enable is the logical AND of `ctl_bl_en` and the permitted window (codes 0xB and 0x8).
- R10: Target-on is sampled only at codes 0x0 and 0x8. A request change in mid-sequence lets the running sequence finish first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_target_on | input | 1 | Requested panel state: 1 on, 0 off |
| ctl_force_supply | input | 1 | Hold the panel supply on outside a sequence |
| ctl_seq_run | input | 1 | Sequencer enable; low halts and darkens the panel |
| ctl_bl_en | input | 1 | Software backlight request |
| dly_on | input | DLY_W | Ticks per power-up sub-step |
| dly_off | input | DLY_W | Ticks per power-down sub-step |
| dly_cycle | input | DLY_W | Ticks of mandatory off-time |
| supply_en | output | 1 | Panel supply enable |
| signal_en | output | 1 | Panel signal enable |
| backlight_en | output | 1 | Backlight enable |
| status | output | 32 | Status word |

## Verification
The bench drives three sequences in a row: up, down, up. The first power-up follows the release from halt, and the second is requested at the moment the down sequence lands in off-idle. Both must wait the full off-time, which separates a correct hold from one that skips or shortens the off-time. In the second power-up, target-on is dropped during a mid-step. This shows the difference between sampling the request only when idle and aborting the sequence. A scoreboard compares every state code in order, with its dwell time and the enables seen on entry. Force-supply and an all-clear are applied last, to separate supply forcing from sequence state.

// File: rtl/pnl_pwr_pkg.sv
package pnl_pwr_pkg;

    typedef enum logic [3:0] {
        ST_OFF = 4'h0,
        ST_DN1 = 4'h1,
        ST_DN2 = 4'h2,
        ST_DN3 = 4'h3,
        ST_ON  = 4'h8,
        ST_UP1 = 4'h9,
        ST_UP2 = 4'hA,
        ST_UP3 = 4'hB,
        ST_RST = 4'hF
    } pnl_state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } pnl_dir_e;

    typedef enum logic [1:0] {
        DSEL_ON,
        DSEL_OFF,
        DSEL_CYC
    } pnl_dsel_e;

    typedef struct packed {
        logic supply;
        logic signal;
        logic bl_ok;
    } pnl_rails_t;

    localparam int unsigned SB_LIVE  = 31;
    localparam int unsigned SB_READY = 30;
    localparam int unsigned SB_DIR   = 28;
    localparam int unsigned SB_CYC   = 27;

    function automatic pnl_dir_e dir_of(input pnl_state_e s);
        case (s)
            ST_UP1, ST_UP2, ST_UP3: return DIR_UP;
            ST_DN1, ST_DN2, ST_DN3: return DIR_DOWN;
            default:                return DIR_NONE;
        endcase
    endfunction

    function automatic pnl_rails_t rails_of(input pnl_state_e s);
        pnl_rails_t r;
        r = '0;
        case (s)
            ST_UP1:         r = '{supply: 1'b1, signal: 1'b0, bl_ok: 1'b0};
            ST_UP2:         r = '{supply: 1'b1, signal: 1'b1, bl_ok: 1'b0};
            ST_UP3, ST_ON:  r = '{supply: 1'b1, signal: 1'b1, bl_ok: 1'b1};
            ST_DN1:         r = '{supply: 1'b1, signal: 1'b1, bl_ok: 1'b0};
            ST_DN2:         r = '{supply: 1'b1, signal: 1'b0, bl_ok: 1'b0};
            default:        r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_live(input pnl_state_e s);
        return (s != ST_OFF) && (s != ST_RST);
    endfunction

    function automatic pnl_dsel_e dsel_of(input pnl_state_e s);
        case (dir_of(s))
            DIR_UP:   return DSEL_ON;
            DIR_DOWN: return DSEL_OFF;
            default:  return DSEL_CYC;
        endcase
    endfunction

    function automatic logic [31:0] pack_status(input pnl_state_e s,
                                                input logic ready,
                                                input logic cyc);
        logic [31:0] w;
        w = '0;
        w[SB_LIVE]          = is_live(s);
        w[SB_READY]         = ready;
        w[SB_DIR+1:SB_DIR]  = dir_of(s);
        w[SB_CYC]           = cyc;
        w[3:0]              = s;
        return w;
    endfunction

endpackage

// File: rtl/pnl_step_timer.sv
module pnl_step_timer #(
    parameter int DLY_W    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DLY_W-1:0] limit,
    output logic             done
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic [DLY_W-1:0] cnt;

    // >= so a limit lowered mid-step still terminates the step
    assign done = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre <= '0;
            cnt <= '0;
        end else if (!done) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                cnt <= cnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pnl_seq_fsm.sv
module pnl_seq_fsm
    import pnl_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       want_on,
    input  logic       step_done,
    output pnl_state_e state,
    output logic       cyc_act,
    output logic       restart,
    output pnl_dsel_e  dsel
);
    pnl_state_e state_n;
    logic       cyc_n;

    always_comb begin
        state_n = state;
        cyc_n   = cyc_act;
        if (!run) begin
            state_n = ST_RST;
            cyc_n   = 1'b0;
        end else begin
            case (state)
                ST_RST: begin
                    state_n = ST_OFF;
                    cyc_n   = 1'b1;
                end
                ST_OFF: begin
                    if (cyc_act) begin
                        if (step_done) cyc_n = 1'b0;
                    end else if (want_on) begin
                        state_n = ST_UP1;
                    end
                end
                ST_UP1: if (step_done) state_n = ST_UP2;
                ST_UP2: if (step_done) state_n = ST_UP3;
                ST_UP3: if (step_done) state_n = ST_ON;
                ST_ON:  if (!want_on)  state_n = ST_DN1;
                ST_DN1: if (step_done) state_n = ST_DN2;
                ST_DN2: if (step_done) state_n = ST_DN3;
                ST_DN3: begin
                    if (step_done) begin
                        state_n = ST_OFF;
                        cyc_n   = 1'b1;
                    end
                end
                default: state_n = ST_RST;
            endcase
        end
    end

    assign restart = (state_n != state);
    assign dsel    = dsel_of(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RST;
            cyc_act <= 1'b0;
        end else begin
            state   <= state_n;
            cyc_act <= cyc_n;
        end
    end
endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
    import pnl_pwr_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_target_on,
    input  logic             ctl_force_supply,
    input  logic             ctl_seq_run,
    input  logic             ctl_bl_en,
    input  logic [DLY_W-1:0] dly_on,
    input  logic [DLY_W-1:0] dly_off,
    input  logic [DLY_W-1:0] dly_cycle,
    output logic             supply_en,
    output logic             signal_en,
    output logic             backlight_en,
    output logic [31:0]      status
);
    pnl_state_e       state;
    pnl_dsel_e        dsel;
    pnl_rails_t       rails;
    logic             cyc_act;
    logic             restart;
    logic             step_done;
    logic [DLY_W-1:0] step_limit;

    always_comb begin
        case (dsel)
            DSEL_ON:  step_limit = dly_on;
            DSEL_OFF: step_limit = dly_off;
            default:  step_limit = dly_cycle;
        endcase
    end

    pnl_step_timer #(
        .DLY_W    (DLY_W),
        .TICK_DIV (TICK_DIV)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (step_limit),
        .done    (step_done)
    );

    pnl_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl_seq_run),
        .want_on   (ctl_target_on),
        .step_done (step_done),
        .state     (state),
        .cyc_act   (cyc_act),
        .restart   (restart),
        .dsel      (dsel)
    );

    assign rails        = rails_of(state);
    assign supply_en    = ctl_seq_run && (ctl_force_supply || rails.supply);
    assign signal_en    = ctl_seq_run && rails.signal;
    assign backlight_en = ctl_seq_run && rails.bl_ok && ctl_bl_en;
    assign status       = pack_status(state, state != ST_RST, cyc_act);
endmodule

// File: rtl/pnl_pwr_seq_chk.sv
module pnl_pwr_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        supply_en,
    input logic        signal_en,
    input logic        backlight_en,
    input logic [31:0] status
);
    AST_HALT_DARK: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!supply_en && !signal_en && !backlight_en)); // R1
    AST_HALT_CODE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (status[3:0] == 4'hF)); // R1
    AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        status[29:28] != 2'b11); // R2
    AST_SIGNAL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        signal_en |-> supply_en); // R3
    AST_BL_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (rst)
        backlight_en |-> signal_en); // R3
    AST_UP_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        (status[3:0] == 4'h9 && $past(status[3:0]) != 4'h9) |-> $past(status[3:0]) == 4'h0); // R3
    AST_DOWN_FROM_ON: assert property (@(posedge clk) disable iff (rst)
        (status[3:0] == 4'h1 && $past(status[3:0]) != 4'h1) |-> $past(status[3:0]) == 4'h8); // R4
    AST_OFF_NOT_LIVE: assert property (@(posedge clk) disable iff (rst)
        (status[3:0] == 4'h0) |-> !status[31]); // R6
    AST_HOLD_IN_OFFTIME: assert property (@(posedge clk) disable iff (rst)
        (status[27] && status[3:0] == 4'h0) |=> status[3:0] != 4'h9); // R7
endmodule

bind pnl_pwr_seq pnl_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .run          (ctl_seq_run),
    .supply_en    (supply_en),
    .signal_en    (signal_en),
    .backlight_en (backlight_en),
    .status       (status)
);

// File: tb/pnl_pwr_seq_test.sv
module pnl_pwr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW      = 8;
    localparam int DIV     = 4;
    localparam int D_ON    = 3;
    localparam int D_OFF   = 2;
    localparam int D_CYC   = 5;
    localparam int UPSTEP  = D_ON * DIV + 1;
    localparam int DNSTEP  = D_OFF * DIV + 1;
    localparam int CYCWAIT = D_CYC * DIV + 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          target_on, force_sup, seq_run, bl_en;
    logic [DW-1:0] d_on, d_off, d_cyc;
    logic          supply_en, signal_en, backlight_en;
    logic [31:0]   status;

    always #(CLK_PERIOD/2) clk = ~clk;

    pnl_pwr_seq #(.DLY_W(DW), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst),
        .ctl_target_on(target_on), .ctl_force_supply(force_sup),
        .ctl_seq_run(seq_run), .ctl_bl_en(bl_en),
        .dly_on(d_on), .dly_off(d_off), .dly_cycle(d_cyc),
        .supply_en(supply_en), .signal_en(signal_en),
        .backlight_en(backlight_en), .status(status)
    );

    typedef struct {
        logic [3:0] code;
        int         dwell;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    exp_t       item;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         mon_on = 0;
    bit         ended = 0;
    logic [3:0] last_code;
    int         dwell;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_rails(input logic [3:0] c, input logic bl);
        logic s, g, b;
        s = (c == 4'h1) || (c == 4'h2) || (c == 4'h8) || (c == 4'h9) ||
            (c == 4'hA) || (c == 4'hB);
        g = (c == 4'h1) || (c == 4'h8) || (c == 4'hA) || (c == 4'hB);
        b = ((c == 4'h8) || (c == 4'hB)) && bl;
        return {s, g, b};
    endfunction

    task automatic push(input logic [3:0] c, input int d, input string t);
        exp_t e;
        e.code = c; e.dwell = d; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic wait_code(input logic [3:0] c);
        while (status[3:0] != c) @(negedge clk);
    endtask

    // scoreboard monitor: order, dwell and enables of each state code (R3, R4, R5)
    always @(negedge clk) begin
        if (mon_on) begin
            if (status[3:0] != last_code) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected state", {28'd0, status[3:0]}, 32'hFFFFFFFF);
                end else begin
                    item = sb.pop_front();
                    check(status[3:0] == item.code, "R3 R4 state order",
                          {28'd0, status[3:0]}, {28'd0, item.code});
                    if (item.dwell != 0)
                        check(dwell == item.dwell, item.tag, dwell, item.dwell);
                    if (!force_sup)
                        check({supply_en, signal_en, backlight_en} ==
                              exp_rails(status[3:0], bl_en), "R3 R4 rails on entry",
                              {29'd0, supply_en, signal_en, backlight_en},
                              {29'd0, exp_rails(status[3:0], bl_en)});
                end
                last_code = status[3:0];
                dwell = 1;
            end else begin
                dwell++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; seq_run = 1'b0; target_on = 1'b0; force_sup = 1'b0; bl_en = 1'b0;
        d_on = DW'(D_ON); d_off = DW'(D_OFF); d_cyc = DW'(D_CYC);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status == 32'h0000000F, "R1 reset status", status, 32'h0000000F);
        check({supply_en, signal_en, backlight_en} == 3'b000, "R1 reset enables",
              {29'd0, supply_en, signal_en, backlight_en}, 32'd0);

        // requests while halted have no effect
        target_on = 1'b1; bl_en = 1'b1;
        repeat (4) @(negedge clk);
        check(status == 32'h0000000F, "R1 request ignored while halted", status, 32'h0000000F);
        check(supply_en == 1'b0, "R1 supply stays off", {31'd0, supply_en}, 32'd0);

        // first power-up: leaves halt through full off-time
        last_code = 4'hF; dwell = 0; mon_on = 1;
        push(4'h0, 0,       "R1 leave halt");
        push(4'h9, CYCWAIT, "R7 off-time after halt");
        push(4'hA, UPSTEP,  "R5 up step 1");
        push(4'hB, UPSTEP,  "R5 up step 2");
        push(4'h8, UPSTEP,  "R5 up step 3");
        seq_run = 1'b1;
        @(negedge clk);
        check(status == 32'h48000000, "R7 off-time flag after halt", status, 32'h48000000);
        repeat (8) @(negedge clk);
        check(status[3:0] == 4'h0 && status[27], "R7 request held in off-time",
              status, 32'h48000000);
        wait_code(4'h8);
        check(status == 32'hC0000008, "R6 power-up complete", status, 32'hC0000008);
        check({supply_en, signal_en, backlight_en} == 3'b111, "R9 backlight granted",
              {29'd0, supply_en, signal_en, backlight_en}, 32'd7);
        bl_en = 1'b0;
        #1;
        check(backlight_en == 1'b0, "R9 backlight follows request",
              {31'd0, backlight_en}, 32'd0);
        bl_en = 1'b1;
        @(negedge clk);

        // power-down
        push(4'h1, 0,      "R4 down start");
        push(4'h2, DNSTEP, "R5 down step 1");
        push(4'h3, DNSTEP, "R5 down step 2");
        push(4'h0, DNSTEP, "R5 down step 3");
        target_on = 1'b0;
        wait_code(4'h1);
        check(status == 32'hE0000001, "R2 down status", status, 32'hE0000001);
        wait_code(4'h0);
        check(status == 32'h48000000, "R7 off-time flag after down", status, 32'h48000000);

        // second power-up requested at once; must wait full off-time
        push(4'h9, CYCWAIT, "R7 second power-up waits");
        push(4'hA, UPSTEP,  "R5 up step 1");
        push(4'hB, UPSTEP,  "R10 up continues after drop");
        push(4'h8, UPSTEP,  "R10 up finishes");
        push(4'h1, 1,       "R10 down follows at once");
        push(4'h2, DNSTEP,  "R5 down step 1");
        push(4'h3, DNSTEP,  "R5 down step 2");
        push(4'h0, DNSTEP,  "R5 down step 3");
        target_on = 1'b1;
        wait_code(4'hA);
        check(status == 32'hD000000A, "R2 up status", status, 32'hD000000A);
        target_on = 1'b0;
        wait_code(4'h8);
        check(status == 32'hC0000008, "R10 up completed despite drop", status, 32'hC0000008);
        wait_code(4'h0);
        repeat (CYCWAIT + 2) @(negedge clk);
        check(status == 32'h40000000, "R6 power-down complete", status, 32'h40000000);

        // force supply
        force_sup = 1'b1;
        #1;
        check({supply_en, signal_en} == 2'b10, "R8 force raises supply only",
              {30'd0, supply_en, signal_en}, 32'd2);
        @(negedge clk);
        check(status == 32'h40000000, "R8 force leaves code", status, 32'h40000000);

        // clear everything
        push(4'hF, 0, "R8 all cleared");
        force_sup = 1'b0; target_on = 1'b0; bl_en = 1'b0; seq_run = 1'b0;
        #1;
        check({supply_en, signal_en, backlight_en} == 3'b000, "R8 all dark at once",
              {29'd0, supply_en, signal_en, backlight_en}, 32'd0);
        @(negedge clk);
        check(status == 32'h0000000F, "R8 halted code", status, 32'h0000000F);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R5 every expected step seen", sb.size(), 32'd0);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule